// File: doc/BRIEF.md
# Shared Address/Data Configuration Register Port

This block lets an asynchronous host load a small bank of configuration registers over a single 8-bit bus, qualified by one active-low strobe. The top bus bit tells the block what the lower seven bits carry. When it is low they are a register address. When it is high they are a data value. A data value always goes to the register named by the most recently loaded address, so the host can send one address and then any number of data values.

The strobe and the bus come from another clock domain. Both pass through two flops. A transaction takes effect when the synchronized strobe returns high, and it uses the synchronized bus value seen at that moment. Each register appears as a parallel output. The block also outputs the three upper address bits, which play no part in register selection and are kept for a readback path. A single control bit decodes the operating mode. Each accepted data write gives a one-cycle pulse and the index of the register written.

Top module: `cfg_port_mux`

## Requirements
- R1: After reset, every register, the latched address (and so `addr_hi_o`), `wr_pulse_o` and `readback_mode_o` are zero.
- R2: A transaction with bus bit 7 low loads bits 6:0 as the current address. It changes no register and gives no write pulse. `addr_hi_o` then shows address bits 6:4.
- R3: A transaction with bus bit 7 high stores bus bits 6:0 into the register selected by address bits 3:0. Register k appears on `regs_o[7*k+6:7*k]`. Address bits 6:4 do not affect selection.
- R4: The current address stays in effect across any number of data transactions, until the next address transaction.
- R5: A data transaction while address bits 3:0 hold 12 to 15 changes no register and gives no write pulse.
- R6: Each accepted data write gives `wr_pulse_o` high for exactly one clock cycle. During that cycle `wr_idx_o` holds the index of the register written.
- R7: A transaction takes effect on the third rising clock edge after `strobe_n_i` returns high, and not earlier. Holding the strobe low for any length of time has no effect before it returns high.
- R8: `readback_mode_o` equals bit 5 of register 1. High selects readback and low selects data collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_i | input | 8 | Shared bus. Bit 7 selects address (0) or data (1); bits 6:0 carry the value |
| strobe_n_i | input | 1 | Active-low transaction strobe, idle high, asynchronous to clk |
| regs_o | output | 84 | All twelve 7-bit registers, register k at bits 7k+6:7k |
| addr_hi_o | output | 3 | Bits 6:4 of the latched address |
| wr_pulse_o | output | 1 | One-cycle pulse per accepted data write |
| wr_idx_o | output | 4 | Index of the register written, valid with the pulse |
| readback_mode_o | output | 1 | Mode select decoded from register 1 bit 5 |

## Verification
The assertions assume the bus is stable from before the strobe falls until several clock cycles after it rises. Under that assumption the synchronized bus and the synchronized strobe edge refer to the same transaction. They also assume each strobe low and high phase lasts at least two clock cycles, so the synchronizer never misses an edge. Every bench transaction sets the bus two cycles before the strobe falls. It holds the strobe low for at least four cycles and keeps the bus unchanged for six cycles after the strobe rises.

// File: rtl/cfg_port_mux.sv
module cfg_port_mux #(
  parameter int NREG     = 12,
  parameter int DW       = 7,
  parameter int SEL_W    = 4,
  parameter int MODE_REG = 1,
  parameter int MODE_BIT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW:0]          bus_i,
  input  logic                 strobe_n_i,
  output logic [NREG*DW-1:0]   regs_o,
  output logic [DW-SEL_W-1:0]  addr_hi_o,
  output logic                 wr_pulse_o,
  output logic [SEL_W-1:0]     wr_idx_o,
  output logic                 readback_mode_o
);
  localparam int BUS_W = DW + 1;
  localparam int HI_W  = DW - SEL_W;

  logic [BUS_W-1:0] bus_m, bus_s;
  logic [2:0]       stb_q;
  logic [DW-1:0]    addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_m <= '0;
      bus_s <= '0;
      stb_q <= 3'b111;
    end else begin
      bus_m <= bus_i;
      bus_s <= bus_m;
      stb_q <= {stb_q[1:0], strobe_n_i};
    end
  end

  wire commit  = stb_q[1] & ~stb_q[2];
  wire is_data = bus_s[BUS_W-1];
  wire [SEL_W-1:0] sel = addr_q[SEL_W-1:0];
  wire sel_ok  = int'(sel) < NREG;
  wire wr_go   = commit & is_data & sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      wr_pulse_o <= 1'b0;
      wr_idx_o   <= '0;
    end else begin
      if (commit && !is_data) addr_q <= bus_s[DW-1:0];
      wr_pulse_o <= wr_go;
      if (wr_go) wr_idx_o <= sel;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_o[k*DW +: DW] <= '0;
      else if (wr_go && int'(sel) == k)
        regs_o[k*DW +: DW] <= bus_s[DW-1:0];
    end
  end

  assign addr_hi_o       = addr_q[DW-1 -: HI_W];
  assign readback_mode_o = regs_o[MODE_REG*DW + MODE_BIT];

  a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |=> !wr_pulse_o);
  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |-> int'(wr_idx_o) < NREG);
  a_r5_no_pulse_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !sel_ok) |=> !wr_pulse_o);
  a_r2_addr_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !is_data) |=> (!wr_pulse_o && $stable(regs_o)));
  a_r3_value_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse_o |-> regs_o[wr_idx_o*DW +: DW] == $past(bus_s[DW-1:0]));
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(regs_o) && $stable(addr_hi_o)));
endmodule

// File: tb/cfg_port_mux_test.sv
module cfg_port_mux_test;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus = 8'h00;
  logic        stb_n = 1;
  logic [83:0] regs;
  logic [2:0]  addr_hi;
  logic        pulse;
  logic [3:0]  idx;
  logic        mode;

  int checks = 0, errors = 0;
  int pulses = 0;
  logic [3:0] last_idx = 0;
  logic [6:0] exp_r [12];

  cfg_port_mux uut (.clk(clk), .rst_n(rst_n), .bus_i(bus), .strobe_n_i(stb_n),
    .regs_o(regs), .addr_hi_o(addr_hi), .wr_pulse_o(pulse), .wr_idx_o(idx),
    .readback_mode_o(mode));

  always #10 clk = ~clk;

  always @(negedge clk) if (pulse) begin pulses++; last_idx = idx; end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_bank(string req);
    for (int k = 0; k < 12; k++) chk(req, regs[k*7 +: 7], exp_r[k]);
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); bus = b;
    repeat (2) @(negedge clk); stb_n = 0;
    repeat (4) @(negedge clk); stb_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 12; k++) exp_r[k] = 0;
    chk_bank("R1");
    chk("R1 addr_hi", addr_hi, 0);
    chk("R1 pulse", pulse, 0);
    chk("R1 mode", mode, 0);
  endtask

  task automatic t_timing;
    int p0;
    send(8'h03);
    @(negedge clk); bus = 8'hD5;
    repeat (2) @(negedge clk); stb_n = 0;
    repeat (20) @(negedge clk);
    chk("R7 held low", regs[3*7 +: 7], 0);
    p0 = pulses;
    stb_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 before 3rd edge", regs[3*7 +: 7], 0);
    chk("R7 no early pulse", pulse, 0);
    @(negedge clk);
    chk("R7 at 3rd edge", regs[3*7 +: 7], 7'h55);
    chk("R6 pulse high", pulse, 1);
    chk("R6 idx", idx, 3);
    @(negedge clk);
    chk("R6 pulse one cycle", pulse, 0);
    exp_r[3] = 7'h55;
    repeat (4) @(negedge clk);
    chk("R6 pulse count", pulses - p0, 1);
  endtask

  task automatic t_basic;
    send(8'h00); send(8'h92); exp_r[0] = 7'h12;
    send(8'h0B); send(8'hFF); exp_r[11] = 7'h7F;
    chk_bank("R3");
    chk("R6 idx last", last_idx, 11);
  endtask

  task automatic t_persist;
    int p0 = pulses;
    send(8'h05); send(8'h81); send(8'h82); send(8'h83);
    exp_r[5] = 7'h03;
    chk_bank("R4");
    chk("R4 pulses", pulses - p0, 3);
    chk("R4 idx", last_idx, 5);
  endtask

  task automatic t_upper;
    int p0 = pulses;
    send(8'h72);
    chk("R2 addr_hi", addr_hi, 7);
    chk("R2 no pulse", pulses - p0, 0);
    chk_bank("R2 unchanged");
    send(8'hAA); exp_r[2] = 7'h2A;
    chk_bank("R3 upper ignored");
    chk("R3 idx", last_idx, 2);
  endtask

  task automatic t_oob;
    int p0 = pulses;
    send(8'h0C); send(8'h91);
    send(8'h7F); send(8'hEE);
    chk_bank("R5");
    chk("R5 no pulse", pulses - p0, 0);
  endtask

  task automatic t_mode;
    send(8'h01); send(8'hA0); exp_r[1] = 7'h20;
    chk("R8 readback", mode, 1);
    send(8'hDF); exp_r[1] = 7'h5F;
    chk("R8 collection", mode, 0);
    chk_bank("R8 bank");
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_timing;
    t_basic;
    t_persist;
    t_upper;
    t_oob;
    t_mode;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule